// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block connects a processor core to an external 32-bit bus on which address and data share the same wires. Each bus cycle opens with a one-clock address phase, in which the address is driven and a latch strobe is raised for external decode logic. One or more data phases follow, and each one lasts until the external side acknowledges it. A single idle clock then closes the cycle. Cycles carry either one word or a four-word burst. During a burst, a dedicated two-bit word index output steps through the line, so no new address phase is needed between beats.

Stores do not go to the bus directly. They enter a small FIFO of address/data pairs, and the sequencer empties it in the background while the core continues. A dirty cache line being evicted takes four FIFO entries marked as a line, and these leave as one burst write. Reads have priority over draining. A read is held back while the FIFO still holds a store to the same word, or to the same line for a burst read, so that it cannot return stale memory contents.

Top module: `adbus_master`

## Requirements
- R1: While reset is high and after it is released with no request pending: `cyc_n`, `rd_n`, `wr_n` and `data_en_n` are 1; `ale`, `ad_oe` and `dir_tx` are 0; `be_n` is 4'hF; `wb_full` is 0.
- R2: Every cycle begins with exactly one clock in which `ale`=1, `ad_oe`=1, `ad_out` carries the full byte address, `cyc_n`=0, and `data_en_n`, `rd_n` and `wr_n` are all 1.
- R3: Each data beat holds `data_en_n`=0 and `cyc_n`=0 on every clock until a clock edge with `bus_ack`=1. During the beat, `rd_n`=0 for a read or `wr_n`=0 for a write (never both), and `dir_tx` is 1 for a write and 0 for a read.
- R4: `be_n` is the bitwise inverse of the requested byte mask, where bit i set selects byte lane i (`ad_out/ad_in[8i+7:8i]`). A burst read drives `be_n`=4'h0.
- R5: `word_sel` begins at address bits [3:2] and rises by one, modulo 4, after each acknowledged beat. A burst has exactly four beats and a single cycle has one.
- R6: After the last acknowledged beat, exactly one clock follows with `cyc_n`=1, `ale`=0, `rd_n`=`wr_n`=1 and `data_en_n`=1, and only then can the next address phase start.
- R7: On a clock with an acknowledged read beat, `rd_valid`=1 and `rd_data` equals `ad_in`. `rd_last` is 1 only on the final beat.
- R8: The write buffer holds four entries and drains them in push order. `wb_full` is 1 while it holds four entries, and a store presented while it is full is dropped.
- R9: Entries pushed with `st_line`=1 leave as one four-beat burst write that uses the first entry's address, with one entry's data and mask per beat. The burst does not start until four entries are held.
- R10: In an idle clock, a pending read goes ahead of draining, and `rd_accept`=1 marks that clock. A single read waits while any held entry matches address bits [31:2], and a burst read waits while any entry matches bits [31:4].
- R11: During a write data beat, `ad_oe`=1 and `ad_out` carries the data of the entry at the head of the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request, taken on a clock when `wb_full` is 0 |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte mask (bit i = lane i) |
| st_line | input | 1 | Entry is part of a four-entry line write-back |
| wb_full | output | 1 | Write buffer holds four entries |
| rd_req | input | 1 | Read request, held until `rd_accept` |
| rd_addr | input | 32 | Read byte address |
| rd_be | input | 4 | Read byte mask for a single read |
| rd_burst | input | 1 | Read a four-word burst |
| rd_accept | output | 1 | Read taken this clock |
| rd_valid | output | 1 | Read beat data present |
| rd_data | output | 32 | Read beat data |
| rd_last | output | 1 | Final beat of the read |
| ad_out | output | 32 | Shared bus value driven out |
| ad_oe | output | 1 | Bus output enable |
| ad_in | input | 32 | Shared bus value sampled in |
| ale | output | 1 | Address latch strobe |
| data_en_n | output | 1 | Data phase marker, active low |
| dir_tx | output | 1 | 1 = block drives data, 0 = block receives |
| be_n | output | 4 | Byte lane enables, active low |
| word_sel | output | 2 | Word index within the line |
| cyc_n | output | 1 | Cycle in progress, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_ack | input | 1 | Beat acknowledge |

## Verification
A table of single reads and writes is run first. The entries differ in direction, starting word, byte mask and number of wait states, which shows whether the strobes, direction, lane enables and the wait behaviour follow each request. A burst read that starts at word 2 checks the index wrap and the `rd_last` placement. Three further patterns test the cases that separate a correct design from a plausible wrong one. In the first, a store and a read arrive together, which shows that the read wins. In the second, a partial line sits in the buffer with an overlapping read pending, which shows that both the read and the drain are held. In the third, five stores are pushed while a slow read occupies the bus, which shows whether the full flag stops the fifth store and whether the buffer drains in push order.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

    localparam int AW        = 32;
    localparam int DW        = 32;
    localparam int BEW       = DW / 8;
    localparam int BURST_LEN = 4;
    localparam int WB_DEF    = 4;
    localparam int WSEL_W    = $clog2(BURST_LEN);
    localparam int WOFF      = $clog2(BEW);
    localparam int LOFF      = WOFF + WSEL_W;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_TURN
    } phase_e;

    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic [BEW-1:0] be;
        logic           line;
    } wb_entry_t;

    function automatic logic [WSEL_W-1:0] word_of(input logic [AW-1:0] a);
        return a[LOFF-1:WOFF];
    endfunction

    function automatic logic addr_overlap(input logic [AW-1:0] a,
                                          input logic [AW-1:0] b,
                                          input logic          whole_line);
        if (whole_line)
            return a[AW-1:LOFF] == b[AW-1:LOFF];
        return a[AW-1:WOFF] == b[AW-1:WOFF];
    endfunction

endpackage

// File: rtl/adbus_wbuf.sv
module adbus_wbuf
    import adbus_pkg::*;
#(
    parameter int DEPTH = WB_DEF,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  wb_entry_t       push_ent,
    input  logic            pop,
    input  logic [AW-1:0]   probe_addr,
    input  logic            probe_line,
    output wb_entry_t       head,
    output logic [CW-1:0]   count,
    output logic            full,
    output logic            empty,
    output logic            hazard
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    wb_entry_t        slot_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] hit;
    logic [PW-1:0]    wp_q, rp_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                vld_q[wp_q] <= 1'b1;
                wp_q        <= step(wp_q);
            end
            if (pop) begin
                vld_q[rp_q] <= 1'b0;
                rp_q        <= step(rp_q);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push)
            slot_q[wp_q] <= push_ent;
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_probe
            assign hit[i] = vld_q[i] && addr_overlap(slot_q[i].addr, probe_addr, probe_line);
        end
    endgenerate

    assign hazard = |hit;
    assign head   = slot_q[rp_q];
    assign full   = (count == CW'(DEPTH));
    assign empty  = (count == '0);

    // R8: a store is never accepted into a full buffer
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        full |-> !push)
        else $error("write buffer overflow");

    // R8: the bus never retires an entry that is not there
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty)
        else $error("write buffer underflow");

endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
    import adbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_rd,
    input  logic               start_wr,
    input  logic [AW-1:0]      rd_addr_i,
    input  logic [BEW-1:0]     rd_be_i,
    input  logic               rd_burst_i,
    input  wb_entry_t          wr_head_i,
    input  logic               bus_ack,
    input  logic [DW-1:0]      ad_in,
    output logic               idle,
    output logic               pop,
    output logic               rd_valid,
    output logic               rd_last,
    output logic [DW-1:0]      rd_data,
    output logic [DW-1:0]      ad_out,
    output logic               ad_oe,
    output logic               ale,
    output logic               data_en_n,
    output logic               dir_tx,
    output logic               cyc_n,
    output logic               rd_n,
    output logic               wr_n,
    output logic [BEW-1:0]     be_n,
    output logic [WSEL_W-1:0]  word_sel
);

    phase_e            ph_q, ph_d;
    logic              wr_q, burst_q;
    logic [AW-1:0]     addr_q;
    logic [BEW-1:0]    rbe_q;
    logic [WSEL_W-1:0] word_q, beat_q;
    logic              in_addr, in_data, active, beat_done, last_beat, launch;

    assign in_addr   = (ph_q == PH_ADDR);
    assign in_data   = (ph_q == PH_DATA);
    assign active    = in_addr || in_data;
    assign launch    = (ph_q == PH_IDLE) && (start_rd || start_wr);
    assign last_beat = !burst_q || (beat_q == WSEL_W'(BURST_LEN - 1));
    assign beat_done = in_data && bus_ack;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: if (start_rd || start_wr) ph_d = PH_ADDR;
            PH_ADDR: ph_d = PH_DATA;
            PH_DATA: if (beat_done && last_beat) ph_d = PH_TURN;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            wr_q    <= 1'b0;
            burst_q <= 1'b0;
            addr_q  <= '0;
            rbe_q   <= '0;
            word_q  <= '0;
            beat_q  <= '0;
        end else begin
            ph_q <= ph_d;
            if (launch) begin
                wr_q    <= !start_rd;
                burst_q <= start_rd ? rd_burst_i : wr_head_i.line;
                addr_q  <= start_rd ? rd_addr_i : wr_head_i.addr;
                rbe_q   <= rd_burst_i ? '1 : rd_be_i;
                word_q  <= word_of(start_rd ? rd_addr_i : wr_head_i.addr);
                beat_q  <= '0;
            end else if (beat_done) begin
                word_q <= word_q + 1'b1;
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign idle      = (ph_q == PH_IDLE);
    assign pop       = beat_done && wr_q;
    assign rd_valid  = beat_done && !wr_q;
    assign rd_last   = rd_valid && last_beat;
    assign rd_data   = ad_in;

    assign ale       = in_addr;
    assign cyc_n     = !active;
    assign data_en_n = !in_data;
    assign rd_n      = !(in_data && !wr_q);
    assign wr_n      = !(in_data && wr_q);
    assign dir_tx    = active && wr_q;
    assign ad_oe     = in_addr || (in_data && wr_q);
    assign word_sel  = word_q;

    always_comb begin
        if (in_addr)
            ad_out = addr_q;
        else if (in_data && wr_q)
            ad_out = wr_head_i.data;
        else
            ad_out = '0;
    end

    always_comb begin
        if (!active)
            be_n = '1;
        else if (wr_q)
            be_n = ~wr_head_i.be;
        else
            be_n = ~rbe_q;
    end

    // R2: the address phase lasts a single clock
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale)
        else $error("latch strobe longer than one clock");

    // R3: read and write strobes are mutually exclusive and lie inside the cycle
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (!cyc_n && !(rd_n == 1'b0 && wr_n == 1'b0)))
        else $error("strobe conflict");

    // R5: word index steps by one after an acknowledged non-final beat
    assert_word_step_R5: assert property (@(posedge clk) disable iff (rst)
        (beat_done && !last_beat) |=> (word_sel == $past(word_sel) + 1'b1) && !data_en_n)
        else $error("burst word index did not advance");

    // R6: final acknowledge is followed by an idle bus clock
    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        (beat_done && last_beat) |=> (cyc_n && !ale && rd_n && wr_n))
        else $error("missing turnaround clock");

endmodule

// File: rtl/adbus_master.sv
module adbus_master
    import adbus_pkg::*;
#(
    parameter int WB_DEPTH = WB_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               st_valid,
    input  logic [AW-1:0]      st_addr,
    input  logic [DW-1:0]      st_data,
    input  logic [BEW-1:0]     st_be,
    input  logic               st_line,
    output logic               wb_full,
    input  logic               rd_req,
    input  logic [AW-1:0]      rd_addr,
    input  logic [BEW-1:0]     rd_be,
    input  logic               rd_burst,
    output logic               rd_accept,
    output logic               rd_valid,
    output logic [DW-1:0]      rd_data,
    output logic               rd_last,
    output logic [DW-1:0]      ad_out,
    output logic               ad_oe,
    input  logic [DW-1:0]      ad_in,
    output logic               ale,
    output logic               data_en_n,
    output logic               dir_tx,
    output logic [BEW-1:0]     be_n,
    output logic [WSEL_W-1:0]  word_sel,
    output logic               cyc_n,
    output logic               rd_n,
    output logic               wr_n,
    input  logic               bus_ack
);

    localparam int CW = $clog2(WB_DEPTH + 1);

    wb_entry_t     push_ent, head;
    logic [CW-1:0] wb_count;
    logic          push, pop, wb_empty, hazard, seq_idle, drain_ok, start_wr;

    assign push_ent = '{addr: st_addr, data: st_data, be: st_be, line: st_line};
    assign push     = st_valid && !wb_full;

    adbus_wbuf #(.DEPTH(WB_DEPTH), .CW(CW)) wbuf_i (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_ent   (push_ent),
        .pop        (pop),
        .probe_addr (rd_addr),
        .probe_line (rd_burst),
        .head       (head),
        .count      (wb_count),
        .full       (wb_full),
        .empty      (wb_empty),
        .hazard     (hazard)
    );

    // a line group drains only once all of its beats are buffered
    assign drain_ok  = !wb_empty && (!head.line || wb_count >= CW'(BURST_LEN));
    assign rd_accept = seq_idle && rd_req && !hazard;
    assign start_wr  = seq_idle && !rd_accept && drain_ok;

    adbus_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_rd   (rd_accept),
        .start_wr   (start_wr),
        .rd_addr_i  (rd_addr),
        .rd_be_i    (rd_be),
        .rd_burst_i (rd_burst),
        .wr_head_i  (head),
        .bus_ack    (bus_ack),
        .ad_in      (ad_in),
        .idle       (seq_idle),
        .pop        (pop),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last),
        .rd_data    (rd_data),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ale        (ale),
        .data_en_n  (data_en_n),
        .dir_tx     (dir_tx),
        .cyc_n      (cyc_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .be_n       (be_n),
        .word_sel   (word_sel)
    );

    // R9: a write that opens with a line entry finds the whole line buffered
    assert_line_whole_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(ale) && dir_tx && head.line) |-> ($past(wb_count) >= CW'(BURST_LEN)))
        else $error("line burst started early");

    // R10: no read address phase while a matching store is still buffered
    assert_rd_order_R10: assert property (@(posedge clk) disable iff (rst)
        (ale && !dir_tx) |-> !$past(hazard))
        else $error("read passed a matching store");

endmodule

// File: tb/adbus_master_tb_top.sv
module adbus_master_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0, st_line = 1'b0, rd_req = 1'b0, rd_burst = 1'b0, bus_ack = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0, rd_addr = '0, ad_in = '0;
    logic [3:0]  st_be = '0, rd_be = '0;
    logic        wb_full, rd_accept, rd_valid, rd_last, ad_oe, ale, data_en_n, dir_tx, cyc_n, rd_n, wr_n;
    logic [31:0] rd_data, ad_out;
    logic [3:0]  be_n;
    logic [1:0]  word_sel;

    int checks = 0;
    int errors = 0;
    logic [31:0] bdata [4];

    always #4 clk = ~clk;

    adbus_master dut_i (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_be(st_be), .st_line(st_line), .wb_full(wb_full), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_be(rd_be), .rd_burst(rd_burst), .rd_accept(rd_accept), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last(rd_last), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ale(ale), .data_en_n(data_en_n), .dir_tx(dir_tx), .be_n(be_n), .word_sel(word_sel),
        .cyc_n(cyc_n), .rd_n(rd_n), .wr_n(wr_n), .bus_ack(bus_ack)
    );

    // {write, addr, data, byte mask, wait states}
    localparam logic [72:0] VEC [6] = '{
        {1'b1, 32'h1000_0004, 32'hA5A5_0001, 4'hF, 4'd0},
        {1'b1, 32'h2000_0008, 32'h1234_5678, 4'h3, 4'd2},
        {1'b0, 32'h3000_000C, 32'hCAFE_0003, 4'hC, 4'd1},
        {1'b0, 32'h4000_0000, 32'hDEAD_BEEF, 4'hF, 4'd0},
        {1'b1, 32'h5000_0010, 32'h0BAD_F00D, 4'h4, 4'd3},
        {1'b0, 32'h6000_0004, 32'h0000_FFFF, 4'h1, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input logic line);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_line = line;
        @(negedge clk);
        st_valid = 1'b0; st_line = 1'b0;
    endtask

    task automatic issue_read(input logic [31:0] a, input logic [3:0] be, input logic burst);
        bit got = 0;
        rd_req = 1'b1; rd_addr = a; rd_be = be; rd_burst = burst;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (rd_accept) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got, "R10 read accepted", {31'd0, got}, 32'd1);
        @(negedge clk);
        rd_req = 1'b0; rd_burst = 1'b0;
    endtask

    task automatic bus_cycle(input logic wr, input logic [31:0] a, input int beats, input int ws, input logic [3:0] exp_ben);
        bit seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (ale) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen && ad_out == a && ad_oe && !cyc_n && data_en_n && rd_n && wr_n,
            "R2 address phase", ad_out, a);
        @(negedge clk);
        for (int b = 0; b < beats; b++) begin
            for (int w = 0; w < ws; w++) begin
                chk(!data_en_n && !cyc_n && !ale && dir_tx == wr && (wr ? (!wr_n && rd_n) : (!rd_n && wr_n)),
                    "R3 wait state", {27'd0, data_en_n, cyc_n, dir_tx, rd_n, wr_n}, {27'd0, 2'b00, wr, wr, !wr});
                @(negedge clk);
            end
            bus_ack = 1'b1;
            ad_in = wr ? 32'h0 : bdata[b];
            #1;
            chk(!data_en_n && dir_tx == wr && (wr ? !wr_n : !rd_n), "R3 data beat",
                {30'd0, data_en_n, dir_tx}, {30'd0, 1'b0, wr});
            chk(word_sel == 2'(a[3:2] + b), "R5 word index", {30'd0, word_sel}, {30'd0, 2'(a[3:2] + b)});
            chk(be_n == exp_ben, "R4 byte enables", {28'd0, be_n}, {28'd0, exp_ben});
            if (wr)
                chk(ad_oe && ad_out == bdata[b], "R11 write data", ad_out, bdata[b]);
            else
                chk(rd_valid && rd_data == bdata[b] && rd_last == (b == beats - 1), "R7 read data",
                    rd_data, bdata[b]);
            @(negedge clk);
            bus_ack = 1'b0;
        end
        chk(cyc_n && !ale && rd_n && wr_n && data_en_n, "R6 turnaround",
            {28'd0, cyc_n, ale, rd_n, wr_n}, {28'd0, 4'b1011});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        chk(cyc_n && rd_n && wr_n && data_en_n && !ale && !ad_oe && !dir_tx && be_n == 4'hF && !wb_full,
            "R1 in reset", {24'd0, cyc_n, rd_n, wr_n, data_en_n, ale, ad_oe, dir_tx, wb_full}, {24'd0, 8'hF0});
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(cyc_n && !ale && be_n == 4'hF, "R1 after release", {28'd0, be_n}, 32'hF);

        // table of single cycles
        for (int v = 0; v < 6; v++) begin
            logic [72:0] e;
            e = VEC[v];
            bdata[0] = e[39:8];
            if (e[72]) begin
                push_store(e[71:40], e[39:8], e[7:4], 1'b0);
                bus_cycle(1'b1, e[71:40], 1, int'(e[3:0]), ~e[7:4]);
            end else begin
                issue_read(e[71:40], e[7:4], 1'b0);
                bus_cycle(1'b0, e[71:40], 1, int'(e[3:0]), ~e[7:4]);
            end
            @(negedge clk);
        end

        // R5 R7: burst read starting at word 2, all lanes on
        bdata = '{32'h7000_0A0A, 32'h7000_0B0B, 32'h7000_0C0C, 32'h7000_0D0D};
        issue_read(32'h7000_0008, 4'h1, 1'b1);
        bus_cycle(1'b0, 32'h7000_0008, 4, 0, 4'h0);
        @(negedge clk);

        // R10: read and store arrive together, read goes first
        st_valid = 1'b1; st_addr = 32'h8000_0000; st_data = 32'h0000_8888; st_be = 4'hF;
        rd_req = 1'b1; rd_addr = 32'h9000_0004; rd_be = 4'hF;
        #1;
        chk(rd_accept, "R10 read priority", {31'd0, rd_accept}, 32'd1);
        @(negedge clk);
        st_valid = 1'b0; rd_req = 1'b0;
        bdata[0] = 32'h9999_0004;
        bus_cycle(1'b0, 32'h9000_0004, 1, 0, 4'h0);
        bdata[0] = 32'h0000_8888;
        bus_cycle(1'b1, 32'h8000_0000, 1, 0, 4'h0);
        @(negedge clk);

        // R9 R10: partial line held, overlapping read held
        for (int k = 0; k < 3; k++)
            push_store(32'hA000_0000 + 32'(4 * k), 32'hB0B0_0000 + 32'(k), 4'hF, 1'b1);
        repeat (3) @(negedge clk);
        chk(!ale && cyc_n, "R9 partial line waits", {31'd0, ale}, 32'd0);
        rd_req = 1'b1; rd_addr = 32'hA000_0004; rd_be = 4'hF; rd_burst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(!rd_accept && !ale, "R10 hazard holds read", {31'd0, rd_accept}, 32'd0);
            @(negedge clk);
        end
        push_store(32'hA000_000C, 32'hB0B0_0003, 4'hF, 1'b1);
        bdata = '{32'hB0B0_0000, 32'hB0B0_0001, 32'hB0B0_0002, 32'hB0B0_0003};
        bus_cycle(1'b1, 32'hA000_0000, 4, 0, 4'h0);
        issue_read(32'hA000_0004, 4'hF, 1'b0);
        bdata[0] = 32'h0101_0101;
        bus_cycle(1'b0, 32'hA000_0004, 1, 0, 4'h0);
        @(negedge clk);

        // R8: fill during a slow read, fifth store dropped, FIFO order
        issue_read(32'hB000_0000, 4'hF, 1'b0);
        bdata[0] = 32'h0B0B_0B0B;
        fork
            bus_cycle(1'b0, 32'hB000_0000, 1, 12, 4'h0);
            begin
                for (int k = 0; k < 4; k++)
                    push_store(32'hC000_0000 + 32'(4 * k), 32'hC0C0_0000 + 32'(k), 4'hF, 1'b0);
                chk(wb_full, "R8 full flag", {31'd0, wb_full}, 32'd1);
                push_store(32'hC000_0010, 32'hC0C0_0004, 4'hF, 1'b0);
            end
        join
        for (int k = 0; k < 4; k++) begin
            bdata[0] = 32'hC0C0_0000 + 32'(k);
            bus_cycle(1'b1, 32'hC000_0000 + 32'(4 * k), 1, 0, 4'h0);
        end
        begin
            bit extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (ale) extra = 1;
            end
            chk(!extra && !wb_full, "R8 store while full dropped", {31'd0, extra}, 32'd0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule